// File: doc/BRIEF.md
# Dual 8-bit PWM/Toggle Timer

This block holds two 8-bit counting sections, a low one and a high one, and each drives its own output pin. A two-bit mode input selects how the sections work. They can run as two independent timers that toggle their pins. They can run as two independent 256-step PWM generators. They can also be chained into one 16-bit timer, in which the low section keeps its own toggle output or its own PWM output while it prescales the high section. Counting advances only on cycles where the `tick` clock-enable is high. Any section event raises one shared interrupt request.

A small controller decides the operating state. `ST_STOP` clears both sections and holds both pins low. From `ST_STOP`, the transition *start* goes to the state that matches `mode` when `run` is high. The running states are `ST_DUAL_TMR` (mode 0), `ST_DUAL_PWM` (mode 1), `ST_CASC_TMR` (mode 2) and `ST_CASC_PWM` (mode 3). A running state takes the transition *halt* back to `ST_STOP` when `run` drops. It takes the transition *restart* back to `ST_STOP` when `mode` no longer matches the state. After a restart, the next cycle starts the new mode from cleared counters.

Top module: `pwm_toggle_timer`

## Requirements
- R1: While `rst_n` is low, and directly after reset, `out_lo`, `out_hi` and `irq` are 0 and the controller is in `ST_STOP`.
- R2: In `ST_STOP` both pins are 0 and both counters and toggles are cleared. With `run` high, the controller enters the mode's state on the next clock edge, and ticks count from that edge on. Dropping `run`, or changing `mode` while running, returns the controller to `ST_STOP` for one or more cycles.
- R3: Mode 0 (two timers). On each tick, a section whose count equals its match value reloads 0 and inverts its pin. Otherwise its count increments. A pin therefore flips every match+1 ticks and is 0 when the section starts.
- R4: Mode 1 (two PWMs). Each count runs 0 to 255 and wraps. A pin is 1 while its count is below the section's latched duty. A duty of 0 gives a constant 0.
- R5: A new duty value is taken into the latch only when the count wraps from 255 to 0, and also while in `ST_STOP`. A change part way through a period does not alter the pin until the next period starts.
- R6: Mode 2 (cascaded timer). The low section runs as in R3. The high section advances only on a low-section match event, and it toggles `out_hi` when it is at its match value during such an event. The 16-bit period is (lo_match+1)*(hi_match+1) ticks.
- R7: Mode 3 (cascaded with PWM). The low section is a PWM as in R4. The high section advances on each low wrap and toggles `out_hi` at its match value, as in R3.
- R8: `irq` is high for the one cycle after any edge at which either section had a match or wrap event, and for no other cycle.
- R9: Clock edges with `tick` low change no count, toggle or latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Enables counting; low forces `ST_STOP` |
| mode | input | 2 | 0 two timers, 1 two PWMs, 2 cascaded timer, 3 cascaded timer with low PWM |
| tick | input | 1 | Count enable, one step per high cycle |
| lo_match | input | 8 | Low-section reload value for timer use |
| hi_match | input | 8 | High-section reload value for timer use |
| lo_duty | input | 8 | Low-section PWM duty |
| hi_duty | input | 8 | High-section PWM duty |
| out_lo | output | 1 | Low-section output pin |
| out_hi | output | 1 | High-section output pin |
| irq | output | 1 | Merged interrupt request pulse |

## Verification
The hardest case to reach is a high-section toggle in mode 3. It needs 256 low ticks for every high step, so the bench holds `tick` high for more than a thousand cycles with a small high match value. It also changes `mode` while the timer is running, which forces the *restart* path without ever dropping `run`. Duty changes are applied part way through a period, so the scoreboard can show that the old duty holds until the wrap. Stretches of sparse ticks show that edges without a tick change nothing.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

    typedef enum logic [2:0] {
        ST_STOP     = 3'd0,
        ST_DUAL_TMR = 3'd1,
        ST_DUAL_PWM = 3'd2,
        ST_CASC_TMR = 3'd3,
        ST_CASC_PWM = 3'd4
    } pwt_state_e;

    function automatic pwt_state_e mode_state(input logic [1:0] m);
        unique case (m)
            2'd0: mode_state = ST_DUAL_TMR;
            2'd1: mode_state = ST_DUAL_PWM;
            2'd2: mode_state = ST_CASC_TMR;
            default: mode_state = ST_CASC_PWM;
        endcase
    endfunction

endpackage

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
    import pwt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] mode,
    output pwt_state_e state,
    output logic       active,
    output logic       cascade,
    output logic       lo_pwm,
    output logic       hi_pwm
);

    pwt_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // transitions: start, halt, restart
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: begin
                if (run) state_d = mode_state(mode);
            end
            ST_DUAL_TMR, ST_DUAL_PWM, ST_CASC_TMR, ST_CASC_PWM: begin
                if (!run || mode_state(mode) != state_q) state_d = ST_STOP;
            end
            default: state_d = ST_STOP;
        endcase
    end

    // decoded controls
    always_comb begin
        active  = 1'b0;
        cascade = 1'b0;
        lo_pwm  = 1'b0;
        hi_pwm  = 1'b0;
        unique case (state_q)
            ST_STOP: ;
            ST_DUAL_TMR: active = 1'b1;
            ST_DUAL_PWM: begin active = 1'b1; lo_pwm = 1'b1; hi_pwm = 1'b1; end
            ST_CASC_TMR: begin active = 1'b1; cascade = 1'b1; end
            ST_CASC_PWM: begin active = 1'b1; cascade = 1'b1; lo_pwm = 1'b1; end
            default: ;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/pwt_section.sv
module pwt_section #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         adv,
    input  logic         pwm_mode,
    input  logic         active,
    input  logic [W-1:0] match,
    input  logic [W-1:0] duty,
    output logic         evt,
    output logic         pin
);

    localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;
    logic [W-1:0] duty_q;
    logic         tog_q;
    logic         end_hit;

    // period end: wrap in PWM use, match in timer use
    assign end_hit = pwm_mode ? (cnt_q == CNT_TOP) : (cnt_q == match);
    assign evt     = adv & end_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            duty_q <= '0;
            tog_q  <= 1'b0;
        end else if (clear) begin
            cnt_q  <= '0;
            duty_q <= duty;
            tog_q  <= 1'b0;
        end else if (adv) begin
            if (end_hit) begin
                cnt_q <= '0;
                if (pwm_mode) duty_q <= duty;
                else          tog_q  <= ~tog_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pin = active & (pwm_mode ? (cnt_q < duty_q) : tog_q);

endmodule

// File: rtl/pwm_toggle_timer.sv
module pwm_toggle_timer
    import pwt_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [1:0]   mode,
    input  logic         tick,
    input  logic [W-1:0] lo_match,
    input  logic [W-1:0] hi_match,
    input  logic [W-1:0] lo_duty,
    input  logic [W-1:0] hi_duty,
    output logic         out_lo,
    output logic         out_hi,
    output logic         irq
);

    pwt_state_e state_q;
    logic active, cascade, lo_pwm, hi_pwm;
    logic lo_adv, hi_adv, lo_evt, hi_evt;
    logic irq_q;

    pwt_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .mode    (mode),
        .state   (state_q),
        .active  (active),
        .cascade (cascade),
        .lo_pwm  (lo_pwm),
        .hi_pwm  (hi_pwm)
    );

    assign lo_adv = tick & active;
    assign hi_adv = cascade ? lo_evt : lo_adv;

    pwt_section #(.W(W)) u_lo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (~active),
        .adv      (lo_adv),
        .pwm_mode (lo_pwm),
        .active   (active),
        .match    (lo_match),
        .duty     (lo_duty),
        .evt      (lo_evt),
        .pin      (out_lo)
    );

    pwt_section #(.W(W)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (~active),
        .adv      (hi_adv),
        .pwm_mode (hi_pwm),
        .active   (active),
        .match    (hi_match),
        .duty     (hi_duty),
        .evt      (hi_evt),
        .pin      (out_hi)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= lo_evt | hi_evt;
    end

    assign irq = irq_q;

endmodule

// File: rtl/pwt_checker.sv
module pwt_checker
    import pwt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       irq,
    input logic       out_lo,
    input logic       out_hi,
    input pwt_state_e state
);

    // R2: stopped means both pins quiet
    p_stop_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |-> (!out_lo && !out_hi));

    // R8: a request only follows a ticked edge
    p_irq_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick));

    // R9: no tick, same running state -> pins unchanged
    p_hold_no_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(tick) && $stable(state) && state != ST_STOP)
            |-> ($stable(out_lo) && $stable(out_hi)));

    // R6: a high toggle in the cascaded timer coincides with a low toggle
    p_cascade_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CASC_TMR && $stable(state) && out_hi != $past(out_hi))
            |-> (out_lo != $past(out_lo)));

    // R3, R8: a toggle in dual-timer use raises the request
    p_toggle_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DUAL_TMR && $stable(state) && out_lo != $past(out_lo))
            |-> irq);

endmodule

bind pwm_toggle_timer pwt_checker u_pwt_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .irq    (irq),
    .out_lo (out_lo),
    .out_hi (out_hi),
    .state  (state_q)
);

// File: tb/pwm_toggle_timer_bench.sv
`timescale 1ns/100ps
module pwm_toggle_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic [1:0] mode = 2'd0;
    logic       tick = 1'b0;
    logic [7:0] lo_match = 8'd0, hi_match = 8'd0, lo_duty = 8'd0, hi_duty = 8'd0;
    logic       out_lo, out_hi, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    logic [2:0] q_exp[$];
    string      q_tag[$];

    // reference state
    int m_st = 0, m_cl = 0, m_ch = 0, m_dl = 0, m_dh = 0;
    bit m_tl = 0, m_th = 0, m_irq = 0;

    always #2.5 clk = ~clk;

    pwm_toggle_timer u_pwm_toggle_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .tick(tick),
        .lo_match(lo_match), .hi_match(hi_match), .lo_duty(lo_duty), .hi_duty(hi_duty),
        .out_lo(out_lo), .out_hi(out_hi), .irq(irq)
    );

    // one section step: returns the event flag
    function automatic bit step(input bit pwm, input int match, input int duty,
                                inout int cnt, inout bit tog, inout int dl);
        bit ev = 0;
        if (pwm) begin
            if (cnt == 255) begin ev = 1; dl = duty; end
            cnt = (cnt + 1) % 256;
        end else if (cnt == match) begin
            ev = 1; cnt = 0; tog = ~tog;
        end else begin
            cnt = cnt + 1;
        end
        return ev;
    endfunction

    // driver: one cycle, model update, push expected
    task automatic cyc(input bit t);
        bit lp, hp, cs, el, eh;
        bit elo, ehi;
        tick = t;
        @(posedge clk);
        if (m_st == 0) begin
            m_cl = 0; m_ch = 0; m_tl = 0; m_th = 0;
            m_dl = lo_duty; m_dh = hi_duty; m_irq = 0;
            m_st = run ? (int'(mode) + 1) : 0;
        end else begin
            lp = (m_st == 2 || m_st == 4);
            hp = (m_st == 2);
            cs = (m_st >= 3);
            el = 0; eh = 0;
            if (t) el = step(lp, lo_match, lo_duty, m_cl, m_tl, m_dl);
            if (cs ? el : t) eh = step(hp, hi_match, hi_duty, m_ch, m_th, m_dh);
            m_irq = el | eh;
            if (!run || (int'(mode) + 1) != m_st) m_st = 0;
        end
        if (m_st == 0) begin elo = 0; ehi = 0; end
        else begin
            lp = (m_st == 2 || m_st == 4);
            hp = (m_st == 2);
            elo = lp ? (m_cl < m_dl) : m_tl;
            ehi = hp ? (m_ch < m_dh) : m_th;
        end
        q_exp.push_back({elo, ehi, m_irq});
        q_tag.push_back(cur_req);
        @(negedge clk);
    endtask

    // monitor: pops and compares
    always @(negedge clk) begin
        if (q_exp.size() > 0) begin
            logic [2:0] e;
            string tg;
            e  = q_exp.pop_front();
            tg = q_tag.pop_front();
            checks++;
            if ({out_lo, out_hi, irq} !== e) begin
                errors++;
                $display("FAIL %s: {out_lo,out_hi,irq} actual %b expected %b at %0t",
                         tg, {out_lo, out_hi, irq}, e, $time);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        checks++;
        if ({out_lo, out_hi, irq} !== 3'b000) begin
            errors++;
            $display("FAIL R1: actual %b expected 000", {out_lo, out_hi, irq});
        end
        rst_n = 1'b1;
        cur_req = "R1 R2";
        for (int i = 0; i < 6; i++) cyc(1'b1);

        // R3 R8: two timers
        cur_req = "R3 R8";
        mode = 2'd0; lo_match = 8'd2; hi_match = 8'd4; run = 1'b1;
        for (int i = 0; i < 40; i++) cyc(1'b1);
        cur_req = "R9";
        for (int i = 0; i < 60; i++) cyc(i % 3 == 0);

        // R2: halt
        cur_req = "R2";
        run = 1'b0;
        for (int i = 0; i < 4; i++) cyc(1'b1);

        // R4: two PWMs, hi duty 0
        cur_req = "R4";
        mode = 2'd1; lo_duty = 8'd64; hi_duty = 8'd0; run = 1'b1;
        for (int i = 0; i < 600; i++) cyc(1'b1);
        // R5: change duty mid-period
        cur_req = "R5";
        for (int i = 0; i < 100; i++) cyc(1'b1);
        lo_duty = 8'd255; hi_duty = 8'd200;
        for (int i = 0; i < 500; i++) cyc(1'b1);

        // R6: cascaded timer
        cur_req = "R6";
        run = 1'b0; cyc(1'b0);
        mode = 2'd2; lo_match = 8'd3; hi_match = 8'd2; run = 1'b1;
        for (int i = 0; i < 100; i++) cyc(1'b1);
        for (int i = 0; i < 60; i++) cyc(i % 2 == 0);

        // R2 R7: restart by mode change, then cascaded with PWM
        cur_req = "R2 R7";
        mode = 2'd3; lo_duty = 8'd128; hi_match = 8'd1;
        for (int i = 0; i < 1300; i++) cyc(1'b1);

        cur_req = "R8";
        lo_match = 8'd0; hi_match = 8'd0; mode = 2'd0;
        for (int i = 0; i < 20; i++) cyc(1'b1);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule